// File: doc/BRIEF.md
# Peripheral Event Routing Multiplexer

This block routes event lines between on-chip peripherals with no processor involved. It has eight channels. Each channel has its own configuration register, which picks one line from a shared source bus and sets the length of a glitch filter. The chosen line passes through the filter and then a register before it drives the channel output. The source bus carries the external event inputs, which are timer pulses, comparator and converter outputs, and port pin levels. It also carries fifteen clock taps, which a free-running counter inside the block produces.

A single write port loads the configuration. One write names a channel and sets both its source select and its filter length. A write also clears that channel's filter state and output, so no event from the old setting can reach the new one. Select code 0 disables a channel, and every channel is disabled after reset.

Top module: `evt_route_mux`

## Requirements
- R1: Each of the eight channels runs independently. A write, a source or a filter setting on one channel never changes the output of another channel.
- R2: While reset is asserted and after reset is released, every channel output is low and every select is 0 (disabled).
- R3: A channel whose select code is 0 holds its output low, whatever the event bus carries.
- R4: Select code s, for s from 1 to EXT_W, routes event input bit evt_i[s-1] to the channel.
- R5: Select code EXT_W+1+k, for k from 0 to 14, routes clock tap k. Tap k is a one-cycle pulse that repeats every 2^k cycles, so tap 0 is high on every cycle. Over any 2^14 consecutive cycles, tap 14 pulses exactly once.
- R6: The 3-bit filter field f sets N = f+1 samples. The filtered level changes only after the source has been sampled at the new level on N consecutive clock edges. A shorter run is dropped.
- R7: The filter treats falling transitions the same way as rising ones.
- R8: The output register adds one clock. With N=1, a source change sampled at edge E appears on chan_o after edge E+1. With N samples, it appears after edge E+N.
- R9: A configuration write clears the channel output at the write edge, and also clears the filter run count and the filtered level. An event run already in progress at the write must restart from zero.
- R10: Select codes above EXT_W+15 (for example 63) disable the channel the same way code 0 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_ch_i | input | 3 | Channel to write |
| wr_sel_i | input | 6 | Source select code |
| wr_flt_i | input | 3 | Filter length minus one |
| evt_i | input | 32 | External event source bus |
| chan_o | output | 8 | Filtered, registered channel outputs |

## Verification
A configuration write can land on the same clock edge as the sample that would complete a filter run. The bench provokes this on channel 0 with a 3-sample filter. It holds the source high for two edges and then rewrites the channel on the third. The expected result is that no output pulse appears. The output must stay low for four more edges and rise only after a fresh run of three samples. An output that rises one edge after the write shows that the write failed to clear the run.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int unsigned NUM_CH_DEF  = 8;
  localparam int unsigned EXT_W_DEF   = 32;
  localparam int unsigned TAP_NUM_DEF = 15;
  localparam int unsigned FLT_W       = 3;
endpackage

// File: rtl/evr_prescaler.sv
module evr_prescaler #(
  parameter int unsigned TAP_NUM = 15,
  localparam int unsigned CNT_W = (TAP_NUM > 1) ? TAP_NUM - 1 : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [TAP_NUM-1:0] tap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // tap k fires when the low k bits are all ones: once per 2^k cycles
  assign tap_o[0] = 1'b1;
  for (genvar k = 1; k < TAP_NUM; k++) begin : g_tap
    assign tap_o[k] = &cnt_q[k-1:0];
  end
endmodule

// File: rtl/evr_filter.sv
module evr_filter import evr_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [FLT_W-1:0] len_i,
  input  logic             raw_i,
  output logic             level_o
);
  logic [FLT_W-1:0] run_q;
  logic             lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (clr_i) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (raw_i == lvl_q) begin
      run_q <= '0;
    end else if (run_q == len_i) begin
      lvl_q <= raw_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/evr_channel.sv
module evr_channel import evr_pkg::*; #(
  parameter int unsigned SEL_W   = 6,
  parameter int unsigned BUS_W   = 64,
  parameter int unsigned SRC_NUM = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [FLT_W-1:0] cfg_len_i,
  input  logic [BUS_W-1:0] src_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             evt_o
);
  logic [SEL_W-1:0] sel_q;
  logic [FLT_W-1:0] len_q;
  logic             raw, level, sel_ok, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      len_q <= '0;
    end else if (cfg_we_i) begin
      sel_q <= cfg_sel_i;
      len_q <= cfg_len_i;
    end
  end

  assign sel_ok = (sel_q != '0) && (int'(sel_q) < int'(SRC_NUM));
  assign raw    = src_i[sel_q];

  evr_filter u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_we_i),
    .len_i   (len_q),
    .raw_i   (raw),
    .level_o (level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q <= 1'b0;
    else if (cfg_we_i) out_q <= 1'b0;
    else               out_q <= sel_ok & level;
  end

  assign sel_o = sel_q;
  assign evt_o = out_q;
endmodule

// File: rtl/evt_route_mux.sv
module evt_route_mux import evr_pkg::*; #(
  parameter int unsigned NUM_CH  = NUM_CH_DEF,
  parameter int unsigned EXT_W   = EXT_W_DEF,
  parameter int unsigned TAP_NUM = TAP_NUM_DEF,
  localparam int unsigned CH_W    = $clog2(NUM_CH),
  localparam int unsigned SRC_NUM = 1 + EXT_W + TAP_NUM,
  localparam int unsigned SEL_W   = $clog2(SRC_NUM),
  localparam int unsigned BUS_W   = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [FLT_W-1:0]  wr_flt_i,
  input  logic [EXT_W-1:0]  evt_i,
  output logic [NUM_CH-1:0] chan_o
);
  logic [TAP_NUM-1:0]           tap_w;
  logic [BUS_W-1:0]             src_bus;
  logic [NUM_CH-1:0][SEL_W-1:0] sel_all_w;

  evr_prescaler #(.TAP_NUM(TAP_NUM)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_o  (tap_w)
  );

  // code 0 is the constant-low slot; codes past the last source read padding zeros
  assign src_bus = BUS_W'({tap_w, evt_i, 1'b0});

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    evr_channel #(.SEL_W(SEL_W), .BUS_W(BUS_W), .SRC_NUM(SRC_NUM)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_we_i  (wr_en_i && (wr_ch_i == CH_W'(c))),
      .cfg_sel_i (wr_sel_i),
      .cfg_len_i (wr_flt_i),
      .src_i     (src_bus),
      .sel_o     (sel_all_w[c]),
      .evt_o     (chan_o[c])
    );
  end
endmodule

// File: rtl/evt_route_mux_chk.sv
module evt_route_mux_chk #(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned EXT_W   = 32,
  parameter int unsigned TAP_NUM = 15,
  localparam int unsigned CH_W    = $clog2(NUM_CH),
  localparam int unsigned SRC_NUM = 1 + EXT_W + TAP_NUM,
  localparam int unsigned SEL_W   = $clog2(SRC_NUM)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [CH_W-1:0]          wr_ch_i,
  input logic [NUM_CH-1:0]        chan_o,
  input logic [NUM_CH-1:0][SEL_W-1:0] sel_all_i,
  input logic [TAP_NUM-1:0]       tap_i
);
  // R9: the channel just written is low on the next edge
  assert_wr_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !chan_o[$past(wr_ch_i)]);

  // R5: a slower tap only fires together with every faster tap
  assert_tap_nest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tap_i >> 1) & ~tap_i) == '0);

  assert_tap1_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_i[1] |=> !tap_i[1]);

  assert_tap1_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tap_i[1] |=> tap_i[1]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_idle
    // R3 and R10: disabled select codes keep the output low
    assert_idle_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((sel_all_i[c] == '0) || (int'(sel_all_i[c]) >= int'(SRC_NUM))) |-> !chan_o[c]);
  end
endmodule

bind evt_route_mux evt_route_mux_chk #(
  .NUM_CH(NUM_CH), .EXT_W(EXT_W), .TAP_NUM(TAP_NUM)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_ch_i   (wr_ch_i),
  .chan_o    (chan_o),
  .sel_all_i (sel_all_w),
  .tap_i     (tap_w)
);

// File: tb/evt_route_mux_tb.sv
module evt_route_mux_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_ch_i = '0;
  logic [5:0]  wr_sel_i = '0;
  logic [2:0]  wr_flt_i = '0;
  logic [31:0] evt_i = '0;
  logic [7:0]  chan_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  evt_route_mux dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i),
    .wr_sel_i(wr_sel_i), .wr_flt_i(wr_flt_i), .evt_i(evt_i), .chan_o(chan_o)
  );

  // bit1: evt_i[0] driven this step, bit0: chan_o[0] expected before driving
  localparam logic [1:0] VEC [0:15] = '{
    2'b00, 2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b01, 2'b01, 2'b11, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00
  };

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int sel, input int flt);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_ch_i = 3'(ch); wr_sel_i = 6'(sel); wr_flt_i = 3'(flt);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    int pulses;
    int dbl;
    logic prev;
    repeat (3) @(negedge clk_i);
    check(int'(chan_o), 0, "R2 in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(int'(chan_o), 0, "R2 after reset");

    // R6 R7 R8: channel 0 on evt_i[0] with 3-sample filter
    cfg(0, 1, 2);
    for (int i = 0; i < 16; i++) begin
      check(int'(chan_o), int'(VEC[i][0]), $sformatf("R6 R7 R8 vector %0d", i));
      evt_i[0] = VEC[i][1];
      @(negedge clk_i);
    end

    // R9: write lands on the edge that would finish a 3-sample run
    evt_i[0] = 1'b1;
    repeat (2) @(negedge clk_i);
    wr_en_i = 1'b1; wr_ch_i = 3'd0; wr_sel_i = 6'd1; wr_flt_i = 3'd2;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(int'(chan_o[0]), 0, "R9 run restarted");
      @(negedge clk_i);
    end
    check(int'(chan_o[0]), 1, "R9 fresh run completes");

    // R3: disable channel 0 while its source is still high
    cfg(0, 0, 0);
    check(int'(chan_o[0]), 0, "R3 disabled at write");
    repeat (3) @(negedge clk_i);
    check(int'(chan_o[0]), 0, "R3 disabled stays low");
    evt_i[0] = 1'b0;

    // R4 R1: channels 3 and 5 share evt_i[4] with lengths 1 and 8
    cfg(3, 5, 0);
    cfg(5, 5, 7);
    evt_i[4] = 1'b1;
    repeat (2) @(negedge clk_i);
    check(int'(chan_o[3]), 1, "R4 code 5 routes evt_i[4]");
    check(int'(chan_o[5]), 0, "R1 channel 5 keeps own filter");
    repeat (6) @(negedge clk_i);
    check(int'(chan_o[5]), 0, "R6 eight samples not yet passed");
    @(negedge clk_i);
    check(int'(chan_o[5]), 1, "R6 eight samples passed");

    // R9 R1 R8: rewrite channel 3 while high
    cfg(3, 5, 0);
    check(int'(chan_o[3]), 0, "R9 write clears output");
    check(int'(chan_o[5]), 1, "R1 other channel unaffected by write");
    @(negedge clk_i);
    check(int'(chan_o[3]), 0, "R8 output one clock after decision");
    @(negedge clk_i);
    check(int'(chan_o[3]), 1, "R8 output follows");

    // R10: out-of-range select with every event line high
    cfg(3, 63, 0);
    evt_i = '1;
    repeat (3) @(negedge clk_i);
    check(int'(chan_o[3]), 0, "R10 code 63 disabled");
    check(int'(chan_o[5]), 1, "R1 channel 5 still routed");
    evt_i = '0;

    // R5: taps div4 and div1
    cfg(6, 35, 0);
    cfg(7, 33, 0);
    repeat (2) @(negedge clk_i);
    pulses = 0; dbl = 0; prev = chan_o[6];
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_i);
      if (chan_o[6]) pulses++;
      if (chan_o[6] && prev) dbl++;
      prev = chan_o[6];
    end
    check(pulses, 16, "R5 div4 pulse count");
    check(dbl, 0, "R5 div4 one-cycle pulses");
    check(int'(chan_o[7]), 1, "R5 div1 always high");

    // R5: div16384 tap
    cfg(6, 47, 0);
    repeat (2) @(negedge clk_i);
    pulses = 0;
    for (int i = 0; i < 32768; i++) begin
      @(negedge clk_i);
      if (chan_o[6]) pulses++;
    end
    check(pulses, 2, "R5 div16384 pulse count");

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end
endmodule